// File: doc/BRIEF.md
# PCI Target Parity Error Reporter

This block sits beside the target logic of a 32-bit PCI function and watches the shared bus. It checks even parity for every address phase on the bus and for every data phase that completes with this function as target. It keeps the two error bits of the configuration status register, raises a sticky error flag, and drives the parity-error and system-error pins. Both pins are gated by the enable bits of the command register.

The block only reports errors. It has no path that stops or retries a bus cycle. A data parity error lets the transfer complete, so the initiator can decide how to recover. An address parity error does not stop the function from claiming and completing the cycle normally. The claim logic lives outside this block and takes no input from it. Address decoding, mastering and the rest of configuration space are outside this block.

A new address phase is a clock in which FRAME# is low after being high in the previous clock. A target data phase is a clock in which IRDY# and TRDY# are both low and `dev_selected` is high. For each phase the PAR value is sampled in the following clock.

Top module: `pcipar_err_reporter`

## Requirements
- R1: While `rst_n` is low, and after its release until the first error, `perr_n_o` and `serr_n_o` are 1, and `perr_oe_o`, `serr_oe_o`, `stat_parity_det`, `stat_syserr_sig` and `parity_err_seen` are 0.
- R2: The expected PAR for a phase is the XOR of AD[31:0] and C/BE#[3:0] in that phase. A mismatch with PAR in the next clock is a parity error for that phase.
- R3: A target data-phase parity error sets `stat_parity_det` at the clock edge where PAR is sampled, whatever the command enables are.
- R4: For a target data-phase parity error, `perr_n_o` goes low for one clock at the second clock edge after the data phase, but only when `cmd_parity_resp` is 1 at the edge where PAR is sampled. `perr_oe_o` is 1 while `perr_n_o` is low and for one clock after it.
- R5: A clock in which IRDY# or TRDY# is high, or `dev_selected` is low, is not a data phase. A wrong PAR after such a clock has no effect.
- R6: When `cmd_parity_resp` and `cmd_syserr_en` are both 1 and an address parity error occurs, three things happen at the second clock edge after the address phase. `stat_parity_det` and `stat_syserr_sig` are set. `serr_n_o` goes low for exactly one clock, with `serr_oe_o` 1 in that same clock.
- R7: When either command enable is 0, an address parity error sets only `stat_parity_det`. `serr_n_o` stays 1 and `stat_syserr_sig` is unchanged.
- R8: Address parity errors are reported whatever the value of `dev_selected`.
- R9: A status write with `stat_wr` = 1 and `stat_wr_be` = 1 clears `stat_parity_det` where `stat_wr_data[1]` is 1, and clears `stat_syserr_sig` where `stat_wr_data[0]` is 1. With `stat_wr_be` = 0 the write has no effect. A new error in the same clock wins over a clear.
- R10: `parity_err_seen` is set by any detected parity error and is cleared only by reset. Status writes do not clear it.
- R11: Phases with correct parity cause no status change and no pin activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_ad | input | 32 | Address/data bus |
| bus_cbe_n | input | 4 | Command / byte enables, active low |
| bus_par | input | 1 | Bus parity, one clock behind its phase |
| bus_frame_n | input | 1 | FRAME#, active low |
| bus_irdy_n | input | 1 | Initiator ready, active low |
| bus_trdy_n | input | 1 | Target ready, active low |
| dev_selected | input | 1 | This function is the target of the current cycle |
| cmd_parity_resp | input | 1 | Command enable: respond to parity errors |
| cmd_syserr_en | input | 1 | Command enable: system error pin |
| stat_wr | input | 1 | Status register write strobe |
| stat_wr_be | input | 1 | Byte enable for the status byte holding the error bits |
| stat_wr_data | input | 2 | [1] clears detected-parity bit, [0] clears signalled-system-error bit |
| perr_n_o | output | 1 | Parity error pin value, active low |
| perr_oe_o | output | 1 | Output enable for the parity error pin |
| serr_n_o | output | 1 | System error pin value, active low |
| serr_oe_o | output | 1 | Output enable for the system error pin (open drain) |
| stat_parity_det | output | 1 | Status: detected parity error |
| stat_syserr_sig | output | 1 | Status: signalled system error |
| parity_err_seen | output | 1 | Sticky flag for any parity error since reset |

## Verification
The assertions assume that address phases are at least two clocks apart. Rising FRAME# edges guarantee this. They also assume that an address phase never coincides with a completed target data phase, which the bus protocol forbids. The bench builds every transfer from one address clock, optional wait states, one completed data clock and idle clocks, so both conditions always hold. The enables and status writes are held steady across each clock edge, because the bench changes every input only on the falling edge.

// File: rtl/pcipar_pkg.sv
package pcipar_pkg;

  typedef enum logic [1:0] {
    PH_NONE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_kind_e;

  // one phase waiting for its PAR sample
  typedef struct packed {
    phase_kind_e kind;
    logic        parity;
  } phase_rec_t;

  typedef struct packed {
    logic addr_err;
    logic data_err;
  } par_err_t;

endpackage

// File: rtl/pcipar_parity.sv
module pcipar_parity #(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic [AD_W-1:0] ad,
  input  logic [BE_W-1:0] cbe_n,
  output logic            parity
);
  localparam int LANE_W = AD_W / BE_W;

  logic [BE_W-1:0] lane_par;

  // each byte lane folds its own enable bit in, then lanes combine
  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign lane_par[g] = (^ad[g*LANE_W +: LANE_W]) ^ cbe_n[g];
  end

  assign parity = ^lane_par;

endmodule

// File: rtl/pcipar_phase_capture.sv
module pcipar_phase_capture
  import pcipar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic       irdy_n,
  input  logic       trdy_n,
  input  logic       selected,
  input  logic       parity_in,
  output phase_rec_t rec
);
  logic frame_q;
  logic addr_phase;
  logic data_phase;

  assign addr_phase = !frame_n && frame_q;
  assign data_phase = !irdy_n && !trdy_n && selected;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q    <= 1'b1;
      rec.kind   <= PH_NONE;
      rec.parity <= 1'b0;
    end else begin
      frame_q    <= frame_n;
      rec.parity <= parity_in;
      if (addr_phase)      rec.kind <= PH_ADDR;
      else if (data_phase) rec.kind <= PH_DATA;
      else                 rec.kind <= PH_NONE;
    end
  end

endmodule

// File: rtl/pcipar_parity_compare.sv
module pcipar_parity_compare
  import pcipar_pkg::*;
(
  input  phase_rec_t rec,
  input  logic       bus_par,
  output par_err_t   err
);
  logic mismatch;

  assign mismatch     = bus_par ^ rec.parity;
  assign err.addr_err = mismatch && (rec.kind == PH_ADDR);
  assign err.data_err = mismatch && (rec.kind == PH_DATA);

endmodule

// File: rtl/pcipar_status_report.sv
module pcipar_status_report
  import pcipar_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  par_err_t   err,
  input  logic       per_en,
  input  logic       serr_en,
  input  logic       wr,
  input  logic       wr_be,
  input  logic [1:0] wr_data,
  output logic       perr_n,
  output logic       perr_oe,
  output logic       serr_n,
  output logic       serr_oe,
  output logic       det,
  output logic       sig,
  output logic       seen
);
  logic drive_perr;
  logic drive_serr;
  logic clr_det;
  logic clr_sig;

  assign drive_perr = err.data_err && per_en;
  assign drive_serr = err.addr_err && per_en && serr_en;
  assign clr_det    = wr && wr_be && wr_data[1];
  assign clr_sig    = wr && wr_be && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_n  <= 1'b1;
      perr_oe <= 1'b0;
      serr_n  <= 1'b1;
      serr_oe <= 1'b0;
      det     <= 1'b0;
      sig     <= 1'b0;
      seen    <= 1'b0;
    end else begin
      perr_n  <= !drive_perr;
      // sustained pin: keep driving one clock high after a low clock
      perr_oe <= drive_perr || !perr_n;
      serr_n  <= !drive_serr;
      serr_oe <= drive_serr;
      if (err.addr_err || err.data_err) det <= 1'b1;
      else if (clr_det)                 det <= 1'b0;
      if (drive_serr)   sig <= 1'b1;
      else if (clr_sig) sig <= 1'b0;
      if (err.addr_err || err.data_err) seen <= 1'b1;
    end
  end

endmodule

// File: rtl/pcipar_err_reporter.sv
module pcipar_err_reporter
  import pcipar_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] bus_ad,
  input  logic [BE_W-1:0] bus_cbe_n,
  input  logic            bus_par,
  input  logic            bus_frame_n,
  input  logic            bus_irdy_n,
  input  logic            bus_trdy_n,
  input  logic            dev_selected,
  input  logic            cmd_parity_resp,
  input  logic            cmd_syserr_en,
  input  logic            stat_wr,
  input  logic            stat_wr_be,
  input  logic [1:0]      stat_wr_data,
  output logic            perr_n_o,
  output logic            perr_oe_o,
  output logic            serr_n_o,
  output logic            serr_oe_o,
  output logic            stat_parity_det,
  output logic            stat_syserr_sig,
  output logic            parity_err_seen
);
  logic       phase_parity;
  phase_rec_t rec;
  par_err_t   err;

  pcipar_parity #(.AD_W(AD_W), .BE_W(BE_W)) u_parity (
    .ad     (bus_ad),
    .cbe_n  (bus_cbe_n),
    .parity (phase_parity)
  );

  pcipar_phase_capture u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (bus_frame_n),
    .irdy_n    (bus_irdy_n),
    .trdy_n    (bus_trdy_n),
    .selected  (dev_selected),
    .parity_in (phase_parity),
    .rec       (rec)
  );

  pcipar_parity_compare u_compare (
    .rec     (rec),
    .bus_par (bus_par),
    .err     (err)
  );

  pcipar_status_report u_report (
    .clk     (clk),
    .rst_n   (rst_n),
    .err     (err),
    .per_en  (cmd_parity_resp),
    .serr_en (cmd_syserr_en),
    .wr      (stat_wr),
    .wr_be   (stat_wr_be),
    .wr_data (stat_wr_data),
    .perr_n  (perr_n_o),
    .perr_oe (perr_oe_o),
    .serr_n  (serr_n_o),
    .serr_oe (serr_oe_o),
    .det     (stat_parity_det),
    .sig     (stat_syserr_sig),
    .seen    (parity_err_seen)
  );

endmodule

// File: rtl/pcipar_err_reporter_sva.sv
module pcipar_err_reporter_sva (
  input logic clk,
  input logic rst_n,
  input logic bus_irdy_n,
  input logic bus_trdy_n,
  input logic dev_selected,
  input logic cmd_parity_resp,
  input logic cmd_syserr_en,
  input logic perr_n_o,
  input logic perr_oe_o,
  input logic serr_n_o,
  input logic serr_oe_o,
  input logic stat_parity_det,
  input logic stat_syserr_sig,
  input logic parity_err_seen
);

  assert_perr_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> $past(cmd_parity_resp));

  assert_perr_drives_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> perr_oe_o);

  assert_perr_only_after_target_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> $past(!bus_irdy_n && !bus_trdy_n && dev_selected, 2));

  assert_serr_one_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n_o |=> serr_n_o);

  assert_serr_drives_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n_o |-> serr_oe_o);

  assert_sig_with_det_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_syserr_sig) |-> stat_parity_det);

  assert_serr_needs_both_enables_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n_o |-> $past(cmd_parity_resp && cmd_syserr_en));

  assert_sticky_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err_seen |=> parity_err_seen);

  assert_sticky_follows_det_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_parity_det) |-> parity_err_seen);

endmodule

bind pcipar_err_reporter pcipar_err_reporter_sva u_sva (
  .clk             (clk),
  .rst_n           (rst_n),
  .bus_irdy_n      (bus_irdy_n),
  .bus_trdy_n      (bus_trdy_n),
  .dev_selected    (dev_selected),
  .cmd_parity_resp (cmd_parity_resp),
  .cmd_syserr_en   (cmd_syserr_en),
  .perr_n_o        (perr_n_o),
  .perr_oe_o       (perr_oe_o),
  .serr_n_o        (serr_n_o),
  .serr_oe_o       (serr_oe_o),
  .stat_parity_det (stat_parity_det),
  .stat_syserr_sig (stat_syserr_sig),
  .parity_err_seen (parity_err_seen)
);

// File: tb/test_pcipar_err_reporter.sv
module test_pcipar_err_reporter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_ad = '0;
  logic [3:0]  bus_cbe_n = '0;
  logic        bus_par = 1'b0;
  logic        bus_frame_n = 1'b1;
  logic        bus_irdy_n = 1'b1;
  logic        bus_trdy_n = 1'b1;
  logic        dev_selected = 1'b0;
  logic        cmd_parity_resp = 1'b0;
  logic        cmd_syserr_en = 1'b0;
  logic        stat_wr = 1'b0;
  logic        stat_wr_be = 1'b0;
  logic [1:0]  stat_wr_data = '0;
  logic        perr_n_o, perr_oe_o, serr_n_o, serr_oe_o;
  logic        stat_parity_det, stat_syserr_sig, parity_err_seen;

  int vectors = 0;
  int miscompares = 0;
  bit saw_perr = 0;
  bit saw_serr = 0;

  // reference state
  bit m_perr_n = 1, m_perr_oe = 0, m_serr_n = 1, m_serr_oe = 0;
  bit m_det = 0, m_sig = 0, m_seen = 0;
  int m_pend = 0;       // 0 none, 1 address, 2 data
  bit m_pend_par = 0;
  bit m_prev_frame = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcipar_err_reporter i_pcipar_err_reporter (
    .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .bus_cbe_n(bus_cbe_n),
    .bus_par(bus_par), .bus_frame_n(bus_frame_n), .bus_irdy_n(bus_irdy_n),
    .bus_trdy_n(bus_trdy_n), .dev_selected(dev_selected),
    .cmd_parity_resp(cmd_parity_resp), .cmd_syserr_en(cmd_syserr_en),
    .stat_wr(stat_wr), .stat_wr_be(stat_wr_be), .stat_wr_data(stat_wr_data),
    .perr_n_o(perr_n_o), .perr_oe_o(perr_oe_o), .serr_n_o(serr_n_o),
    .serr_oe_o(serr_oe_o), .stat_parity_det(stat_parity_det),
    .stat_syserr_sig(stat_syserr_sig), .parity_err_seen(parity_err_seen)
  );

  // behavioural reference, evaluated at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_perr_n = 1; m_perr_oe = 0; m_serr_n = 1; m_serr_oe = 0;
      m_det = 0; m_sig = 0; m_seen = 0; m_pend = 0; m_prev_frame = 1;
    end else begin
      bit a_err, d_err, syserr;
      a_err  = (m_pend == 1) && (bus_par != m_pend_par);
      d_err  = (m_pend == 2) && (bus_par != m_pend_par);
      syserr = a_err && cmd_parity_resp && cmd_syserr_en;
      m_perr_oe = (d_err && cmd_parity_resp) || !m_perr_n;
      m_perr_n  = !(d_err && cmd_parity_resp);
      m_serr_n  = !syserr;
      m_serr_oe = syserr;
      if (a_err || d_err) m_det = 1;
      else if (stat_wr && stat_wr_be && stat_wr_data[1]) m_det = 0;
      if (syserr) m_sig = 1;
      else if (stat_wr && stat_wr_be && stat_wr_data[0]) m_sig = 0;
      if (a_err || d_err) m_seen = 1;
      if (!bus_frame_n && m_prev_frame) m_pend = 1;
      else if (!bus_irdy_n && !bus_trdy_n && dev_selected) m_pend = 2;
      else m_pend = 0;
      m_pend_par = ^{bus_ad, bus_cbe_n};
      m_prev_frame = bus_frame_n;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    if (rst_n) begin
      chk("R4 perr_n", perr_n_o, m_perr_n);
      chk("R4 perr_oe", perr_oe_o, m_perr_oe);
      chk("R6 serr_n", serr_n_o, m_serr_n);
      chk("R6 serr_oe", serr_oe_o, m_serr_oe);
      chk("R3 status det", stat_parity_det, m_det);
      chk("R6 status sig", stat_syserr_sig, m_sig);
      chk("R10 sticky", parity_err_seen, m_seen);
      if (!perr_n_o) saw_perr = 1;
      if (!serr_n_o) saw_serr = 1;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic xfer(input logic [31:0] a, input logic [3:0] c, input bit abad,
                      input logic [31:0] d, input logic [3:0] be, input bit dbad,
                      input bit tgt, input int waits,
                      input bit wr, input bit wbe, input logic [1:0] wdat);
    bit next_par;
    bus_frame_n = 0; bus_irdy_n = 1; bus_trdy_n = 1;
    bus_ad = a; bus_cbe_n = c; dev_selected = tgt; bus_par = 1'($urandom);
    tick();
    next_par = (^{a, c}) ^ abad;
    for (int i = 0; i < waits; i++) begin
      bus_frame_n = 1; bus_irdy_n = 0; bus_trdy_n = 1;
      bus_ad = $urandom; bus_par = next_par;
      next_par = 1'($urandom);
      tick();
    end
    bus_frame_n = 1; bus_irdy_n = 0; bus_trdy_n = 0;
    bus_ad = d; bus_cbe_n = be; bus_par = next_par;
    tick();
    bus_irdy_n = 1; bus_trdy_n = 1; dev_selected = 0; bus_ad = '0;
    bus_par = (^{d, be}) ^ dbad;
    stat_wr = wr; stat_wr_be = wbe; stat_wr_data = wdat;
    tick();
    stat_wr = 0; bus_par = 0;
    tick();
    tick();
  endtask

  task automatic wr_status(input bit be, input logic [1:0] dat);
    stat_wr = 1; stat_wr_be = be; stat_wr_data = dat;
    tick();
    stat_wr = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 perr_n", perr_n_o, 1); chk("R1 serr_n", serr_n_o, 1);
    chk("R1 oe", {30'd0, perr_oe_o, serr_oe_o}, 0);
    chk("R1 status", {29'd0, stat_parity_det, stat_syserr_sig, parity_err_seen}, 0);

    cmd_parity_resp = 1; cmd_syserr_en = 1;
    // R2 / R11 correct parity on both phases
    saw_perr = 0; saw_serr = 0;
    xfer(32'h1234_5678, 4'h7, 0, 32'hDEAD_BEEF, 4'h0, 0, 1, 1, 0, 0, 2'b00);
    chk("R2 no error on good parity", stat_parity_det, 0);
    chk("R11 no pin activity", {30'd0, saw_perr, saw_serr}, 0);

    // R3 / R4 data error with response enabled
    saw_perr = 0;
    xfer(32'h0000_1000, 4'h6, 0, 32'h0F0F_0F0F, 4'h3, 1, 1, 0, 0, 0, 2'b00);
    chk("R3 det set by data error", stat_parity_det, 1);
    chk("R4 perr pulsed", saw_perr, 1);
    chk("R4 no syserr on data error", stat_syserr_sig, 0);

    // R9 write without byte enable ignored, then clear
    wr_status(0, 2'b11);
    chk("R9 write without byte enable ignored", stat_parity_det, 1);
    wr_status(1, 2'b10);
    chk("R9 det cleared", stat_parity_det, 0);
    chk("R10 sticky survives clear", parity_err_seen, 1);

    // R4 data error with response disabled: status only
    cmd_parity_resp = 0; saw_perr = 0;
    xfer(32'h0000_2000, 4'h7, 0, 32'h1111_0000, 4'h0, 1, 1, 2, 0, 0, 2'b00);
    chk("R3 det set with response off", stat_parity_det, 1);
    chk("R4 perr quiet with response off", saw_perr, 0);
    wr_status(1, 2'b11);

    // R5 non-target data phase and wait-state garbage ignored
    cmd_parity_resp = 1; saw_perr = 0;
    xfer(32'h0000_3000, 4'h6, 0, 32'h2222_2222, 4'h0, 1, 0, 3, 0, 0, 2'b00);
    chk("R5 non-target data error ignored", stat_parity_det, 0);
    chk("R5 no perr", saw_perr, 0);

    // R6 / R8 address error, both enables, not target
    saw_serr = 0;
    xfer(32'h4000_0000, 4'hA, 1, 32'h0, 4'h0, 0, 0, 0, 0, 0, 2'b00);
    chk("R6 sig set", stat_syserr_sig, 1);
    chk("R8 det set on foreign cycle", stat_parity_det, 1);
    chk("R6 serr pulsed", saw_serr, 1);
    wr_status(1, 2'b01);
    chk("R9 sig cleared alone", {30'd0, stat_parity_det, stat_syserr_sig}, 2'b10);
    wr_status(1, 2'b10);

    // R7 either enable clear: status bit only
    cmd_syserr_en = 0; saw_serr = 0;
    xfer(32'h5000_0000, 4'hB, 1, 32'h0, 4'h0, 0, 1, 0, 0, 0, 2'b00);
    chk("R7 det only, serr off", {30'd0, stat_parity_det, stat_syserr_sig}, 2'b10);
    chk("R7 no serr", saw_serr, 0);
    wr_status(1, 2'b10);
    cmd_syserr_en = 1; cmd_parity_resp = 0;
    xfer(32'h6000_0000, 4'hB, 1, 32'h0, 4'h0, 0, 1, 0, 0, 0, 2'b00);
    chk("R7 det only, response off", {30'd0, stat_parity_det, stat_syserr_sig}, 2'b10);
    chk("R7 no serr", saw_serr, 0);
    wr_status(1, 2'b10);

    // R9 set wins over clear in the same clock
    cmd_parity_resp = 1;
    xfer(32'h7000_0000, 4'h7, 0, 32'hAAAA_5555, 4'h1, 1, 1, 0, 1, 1, 2'b11);
    chk("R9 set beats clear", stat_parity_det, 1);
    wr_status(1, 2'b11);

    // mixed traffic checked against the reference every clock
    for (int n = 0; n < 300; n++) begin
      cmd_parity_resp = 1'($urandom); cmd_syserr_en = 1'($urandom);
      xfer($urandom, 4'($urandom), ($urandom % 4) == 0, $urandom, 4'($urandom),
           ($urandom % 3) == 0, 1'($urandom), $urandom % 3,
           1'($urandom), 1'($urandom), 2'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule